// File: doc/BRIEF.md
# UART FIFO Trigger Interrupt Generator

This block raises the FIFO-related interrupt requests of a UART whose receive and transmit FIFOs hold up to 128 characters. It watches the fill counts reported by both FIFOs and compares them with trigger thresholds. It also runs a character-time timer on the receive side, so that a few bytes left below the threshold are still reported to the host. The FIFOs, the serializer and the host bus decoder are separate blocks. They feed this one with fill counts, a push strobe for each new received character, read strobes for the receive data register and the interrupt status register, the current line format, and a tick at twice the bit rate.

Thresholds come from two sources. Four threshold registers can be programmed in single steps: receive level, transmit level, and the high and low flow-control levels. While any of the four is nonzero, the block is in extended mode and the receive and transmit levels are used directly. While all four are zero, two-bit selectors pick from a fixed legacy table. The block reports the three interrupt conditions, a prioritised interrupt code, and copies of the two fill counts limited to the FIFO depth, for the host to read.

Top module: `uart_fifo_irq_gen`

## Requirements
- R1: `ext_mode` is 1 one cycle after any of `rx_lvl_reg`, `tx_lvl_reg`, `flow_hi_reg`, `flow_lo_reg` is nonzero, and 0 one cycle after all four are zero.
- R2: In extended mode a level register value of 1..128 is used as the trigger, 0 is used as 1, and values above 128 are used as 128.
- R3: Outside extended mode the receive selector codes 0,1,2,3 give triggers 8,16,56,60 and the transmit selector codes 0,1,2,3 give triggers 8,16,32,56.
- R4: `rx_data_irq` is 1 one cycle after `rx_count` is at or above the receive trigger, and 0 one cycle after it is below it.
- R5: `tx_irq` sets when `tx_count` first goes below the transmit trigger or first becomes zero, and the set wins over an `isr_rd` in the same cycle. It is cleared by `isr_rd` while the count stays below the trigger, and is forced to 0 whenever the count is at or above the trigger. All changes appear one cycle later. After reset the previous state counts as neither below nor empty.
- R6: One character time in half bits is 2*(1 + data bits + parity) plus the stop length. Data bits are 5 + `wlen_sel`. The stop length is 2 half bits when `stop_sel`=0, 3 when `stop_sel`=1 with 5 data bits, and 4 otherwise. `rx_timeout_irq` goes to 1 on the edge that samples the (4 × character half bits)-th `half_tick` since the last restart.
- R7: A cycle with `rhr_rd` or `rx_push` high restarts the timeout count and clears `rx_timeout_irq` on the next edge. While `rx_count` is zero the count stays idle and `rx_timeout_irq` is 0.
- R8: `irq_id` is 1 when `rx_data_irq` is set. Otherwise it is 2 when `rx_timeout_irq` is set, 3 when `tx_irq` is set, and 0 when none is set. `irq_any` is 1 exactly when `irq_id` is nonzero.
- R9: `rx_level` and `tx_level` follow `rx_count` and `tx_count` one cycle later, limited to 128.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | 8 | Receive FIFO fill count |
| tx_count | input | 8 | Transmit FIFO fill count |
| rx_push | input | 1 | A new character entered the receive FIFO |
| rhr_rd | input | 1 | Host read of the receive data register |
| isr_rd | input | 1 | Host read of the interrupt status register |
| rx_lvl_reg | input | 8 | Programmed receive trigger level |
| tx_lvl_reg | input | 8 | Programmed transmit trigger level |
| flow_hi_reg | input | 8 | Flow-control high threshold (mode decision only) |
| flow_lo_reg | input | 8 | Flow-control low threshold (mode decision only) |
| rx_legacy_sel | input | 2 | Legacy receive trigger selector |
| tx_legacy_sel | input | 2 | Legacy transmit trigger selector |
| wlen_sel | input | 2 | Data bits minus 5 |
| stop_sel | input | 1 | Long stop length select |
| parity_en | input | 1 | Parity bit present |
| half_tick | input | 1 | One pulse per half bit time |
| rx_data_irq | output | 1 | Receive threshold interrupt |
| rx_timeout_irq | output | 1 | Receive timeout interrupt |
| tx_irq | output | 1 | Transmit empty or low-water interrupt |
| irq_id | output | 2 | Prioritised interrupt code |
| irq_any | output | 1 | Any interrupt pending |
| ext_mode | output | 1 | Extended threshold mode active |
| rx_level | output | 8 | Receive occupancy for the host |
| tx_level | output | 8 | Transmit occupancy for the host |

## Verification
The flags, the mode bit and both level outputs are registered, so they reflect the inputs held during one clock cycle after the next rising edge. `irq_id` and `irq_any` follow the registered flags in the same cycle. The bench drives its inputs a little after each rising edge and samples every output just after the following rising edge. For each cycle it computes the expected values from the inputs it held during that cycle. The timeout is counted in `half_tick` pulses rather than clock cycles. The bench delivers exactly one less than the expected character-time budget and checks the flag is still low, then delivers one more and checks it has risen.

// File: rtl/uart_irq_pkg.sv
// Shared types for the UART FIFO interrupt generator.
// Assumes: interrupt codes are consumed by an interrupt status register.
package uart_irq_pkg;

    typedef enum logic [1:0] {
        IRQ_NONE    = 2'd0,
        IRQ_RXDATA  = 2'd1,
        IRQ_TIMEOUT = 2'd2,
        IRQ_TXLOW   = 2'd3
    } irq_id_e;

endpackage

// File: rtl/uart_trig_sel.sv
// Picks one FIFO trigger level: the programmed register in extended mode
// (zero read as one, clamped to the depth), else a fixed legacy table.
// Assumes: legacy table entries fit in CNT_W bits.
module uart_trig_sel #(
    parameter int FIFO_DEPTH = 128,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter bit IS_RX      = 1'b1
) (
    input  logic             ext_mode,
    input  logic [CNT_W-1:0] lvl_reg,
    input  logic [1:0]       legacy_sel,
    output logic [CNT_W-1:0] trig
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    logic [CNT_W-1:0] legacy_raw;

    // Legacy table, variant chosen by direction.
    generate
        if (IS_RX) begin : g_rx_table
            always_comb begin
                case (legacy_sel)
                    2'd0:    legacy_raw = CNT_W'(8);
                    2'd1:    legacy_raw = CNT_W'(16);
                    2'd2:    legacy_raw = CNT_W'(56);
                    default: legacy_raw = CNT_W'(60);
                endcase
            end
        end else begin : g_tx_table
            always_comb begin
                case (legacy_sel)
                    2'd0:    legacy_raw = CNT_W'(8);
                    2'd1:    legacy_raw = CNT_W'(16);
                    2'd2:    legacy_raw = CNT_W'(32);
                    default: legacy_raw = CNT_W'(56);
                endcase
            end
        end
    endgenerate

    // Final trigger: source select, floor at one, clamp at depth.
    always_comb begin
        if (ext_mode) begin
            if (lvl_reg == '0)
                trig = ONE_C;
            else if (lvl_reg > DEPTH_C)
                trig = DEPTH_C;
            else
                trig = lvl_reg;
        end else begin
            trig = (legacy_raw > DEPTH_C) ? DEPTH_C : legacy_raw;
        end
    end
endmodule

// File: rtl/uart_rx_timeout.sv
// Receive character timeout: counts half-bit ticks since the last restart
// and flags four character times of silence while data waits in the FIFO.
// Assumes: half_tick is a single-cycle pulse at twice the bit rate.
module uart_rx_timeout #(
    parameter int CHARS_TMO = 4,
    parameter int MAX_DATA  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic       restart,
    input  logic       fifo_empty,
    input  logic [1:0] wlen_sel,
    input  logic       stop_sel,
    input  logic       parity_en,
    output logic       timeout
);
    localparam int MAX_CHAR_HALF = 2 * (1 + MAX_DATA + 1) + 4;
    localparam int MAX_LIMIT     = CHARS_TMO * MAX_CHAR_HALF;
    localparam int TMO_W         = $clog2(MAX_LIMIT + 1);

    logic [TMO_W-1:0] cnt_q, cnt_nxt, char_half, limit;
    logic [TMO_W-1:0] stop_half, data_bits;
    logic             hold_zero;

    // Character length in half bits from the line format.
    always_comb begin
        data_bits = TMO_W'(5) + TMO_W'(wlen_sel);
        if (!stop_sel)
            stop_half = TMO_W'(2);
        else if (wlen_sel == 2'd0)
            stop_half = TMO_W'(3);
        else
            stop_half = TMO_W'(4);
        char_half = TMO_W'(2) * (TMO_W'(1) + data_bits + TMO_W'(parity_en)) + stop_half;
        limit     = TMO_W'(CHARS_TMO) * char_half;
    end

    // Next count: restart or idle forces zero, ticks advance up to the limit.
    always_comb begin
        hold_zero = restart || fifo_empty;
        if (hold_zero)
            cnt_nxt = '0;
        else if (half_tick && (cnt_q < limit))
            cnt_nxt = cnt_q + TMO_W'(1);
        else
            cnt_nxt = cnt_q;
    end

    // Count and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            timeout <= 1'b0;
        end else begin
            cnt_q   <= cnt_nxt;
            timeout <= !hold_zero && (cnt_nxt >= limit);
        end
    end
endmodule

// File: rtl/uart_tx_irq.sv
// Transmit low-water interrupt: sets on entry below the trigger or on
// becoming empty, clears on status read or once the FIFO refills.
// Assumes: trig is at least one.
module uart_tx_irq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] trig,
    input  logic             isr_rd,
    output logic             tx_irq
);
    logic below, empty, below_q, empty_q, set_evt;

    // Entry events against last cycle's state.
    always_comb begin
        below   = tx_count < trig;
        empty   = tx_count == '0;
        set_evt = (below && !below_q) || (empty && !empty_q);
    end

    // Interrupt flag and history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_irq  <= 1'b0;
            below_q <= 1'b0;
            empty_q <= 1'b0;
        end else begin
            below_q <= below;
            empty_q <= empty;
            if (!below)
                tx_irq <= 1'b0;
            else if (set_evt)
                tx_irq <= 1'b1;
            else if (isr_rd)
                tx_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_fifo_irq_gen.sv
// Top of the UART FIFO interrupt generator: mode decision, trigger
// selection, receive threshold flag, timeout, transmit flag, priority
// code and clamped level copies.
// Assumes: counts and registers are synchronous to clk.
module uart_fifo_irq_gen #(
    parameter int FIFO_DEPTH = 128,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             rx_push,
    input  logic             rhr_rd,
    input  logic             isr_rd,
    input  logic [CNT_W-1:0] rx_lvl_reg,
    input  logic [CNT_W-1:0] tx_lvl_reg,
    input  logic [CNT_W-1:0] flow_hi_reg,
    input  logic [CNT_W-1:0] flow_lo_reg,
    input  logic [1:0]       rx_legacy_sel,
    input  logic [1:0]       tx_legacy_sel,
    input  logic [1:0]       wlen_sel,
    input  logic             stop_sel,
    input  logic             parity_en,
    input  logic             half_tick,
    output logic             rx_data_irq,
    output logic             rx_timeout_irq,
    output logic             tx_irq,
    output logic [1:0]       irq_id,
    output logic             irq_any,
    output logic             ext_mode,
    output logic [CNT_W-1:0] rx_level,
    output logic [CNT_W-1:0] tx_level
);
    import uart_irq_pkg::*;

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

    logic             ext_now;
    logic [CNT_W-1:0] rx_trig, tx_trig;
    irq_id_e          id_c;

    // Extended mode whenever any threshold register is programmed.
    always_comb ext_now = |{rx_lvl_reg, tx_lvl_reg, flow_hi_reg, flow_lo_reg};

    uart_trig_sel #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IS_RX(1'b1)) rx_sel_i (
        .ext_mode   (ext_now),
        .lvl_reg    (rx_lvl_reg),
        .legacy_sel (rx_legacy_sel),
        .trig       (rx_trig)
    );

    uart_trig_sel #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IS_RX(1'b0)) tx_sel_i (
        .ext_mode   (ext_now),
        .lvl_reg    (tx_lvl_reg),
        .legacy_sel (tx_legacy_sel),
        .trig       (tx_trig)
    );

    uart_rx_timeout rx_tmo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_tick  (half_tick),
        .restart    (rhr_rd || rx_push),
        .fifo_empty (rx_count == '0),
        .wlen_sel   (wlen_sel),
        .stop_sel   (stop_sel),
        .parity_en  (parity_en),
        .timeout    (rx_timeout_irq)
    );

    uart_tx_irq #(.CNT_W(CNT_W)) tx_irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_count (tx_count),
        .trig     (tx_trig),
        .isr_rd   (isr_rd),
        .tx_irq   (tx_irq)
    );

    // Registered receive flag, mode bit and clamped level copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_irq <= 1'b0;
            ext_mode    <= 1'b0;
            rx_level    <= '0;
            tx_level    <= '0;
        end else begin
            rx_data_irq <= rx_count >= rx_trig;
            ext_mode    <= ext_now;
            rx_level    <= (rx_count > DEPTH_C) ? DEPTH_C : rx_count;
            tx_level    <= (tx_count > DEPTH_C) ? DEPTH_C : tx_count;
        end
    end

    // Priority encoder: receive data, then timeout, then transmit.
    always_comb begin
        if (rx_data_irq)
            id_c = IRQ_RXDATA;
        else if (rx_timeout_irq)
            id_c = IRQ_TIMEOUT;
        else if (tx_irq)
            id_c = IRQ_TXLOW;
        else
            id_c = IRQ_NONE;
        irq_id  = id_c;
        irq_any = id_c != IRQ_NONE;
    end
endmodule

// File: rtl/uart_fifo_irq_chk.sv
// Assertion checker for uart_fifo_irq_gen, attached by bind.
// Assumes: reset is asserted at time zero.
module uart_fifo_irq_chk #(
    parameter int FIFO_DEPTH = 128,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             rx_push,
    input logic             rhr_rd,
    input logic             rx_data_irq,
    input logic             rx_timeout_irq,
    input logic             tx_irq,
    input logic [1:0]       irq_id,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] tx_level
);
    logic prev_empty_c;

    // Observed transmit-empty history.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_empty_c <= 1'b0;
        else        prev_empty_c <= tx_count == '0;
    end

    AST_RX_EMPTY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !rx_data_irq); // R4
    AST_TMO_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !rx_timeout_irq); // R7
    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd || rx_push) |=> !rx_timeout_irq); // R7
    AST_TX_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_count == '0) && !prev_empty_c) |=> tx_irq); // R5
    AST_TX_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count >= CNT_W'(FIFO_DEPTH)) |=> !tx_irq); // R5
    AST_ID_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_irq |-> (irq_id == 2'd1)); // R8
    AST_ID_TMO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout_irq && !rx_data_irq) |-> (irq_id == 2'd2)); // R8
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= CNT_W'(FIFO_DEPTH)) && (tx_level <= CNT_W'(FIFO_DEPTH))); // R9
endmodule

bind uart_fifo_irq_gen uart_fifo_irq_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_count       (rx_count),
    .tx_count       (tx_count),
    .rx_push        (rx_push),
    .rhr_rd         (rhr_rd),
    .rx_data_irq    (rx_data_irq),
    .rx_timeout_irq (rx_timeout_irq),
    .tx_irq         (tx_irq),
    .irq_id         (irq_id),
    .rx_level       (rx_level),
    .tx_level       (tx_level)
);

// File: tb/uart_fifo_irq_gen_tb.sv
// Bench for uart_fifo_irq_gen: seeded random cycles against a spec model,
// plus directed corners for thresholds, transmit clearing and timeout.
module uart_fifo_irq_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_count = '0, tx_count = '0;
    logic       rx_push = 1'b0, rhr_rd = 1'b0, isr_rd = 1'b0;
    logic [7:0] rx_lvl_reg = '0, tx_lvl_reg = '0, flow_hi_reg = '0, flow_lo_reg = '0;
    logic [1:0] rx_legacy_sel = '0, tx_legacy_sel = '0, wlen_sel = '0;
    logic       stop_sel = 1'b0, parity_en = 1'b0, half_tick = 1'b0;
    logic       rx_data_irq, rx_timeout_irq, tx_irq, irq_any, ext_mode;
    logic [1:0] irq_id;
    logic [7:0] rx_level, tx_level;

    int n_chk = 0, n_fail = 0;
    bit m_pb = 0, m_pe = 0, m_tx = 0;

    always #10 clk = ~clk;

    uart_fifo_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .rx_push(rx_push), .rhr_rd(rhr_rd), .isr_rd(isr_rd),
        .rx_lvl_reg(rx_lvl_reg), .tx_lvl_reg(tx_lvl_reg),
        .flow_hi_reg(flow_hi_reg), .flow_lo_reg(flow_lo_reg),
        .rx_legacy_sel(rx_legacy_sel), .tx_legacy_sel(tx_legacy_sel),
        .wlen_sel(wlen_sel), .stop_sel(stop_sel), .parity_en(parity_en),
        .half_tick(half_tick), .rx_data_irq(rx_data_irq),
        .rx_timeout_irq(rx_timeout_irq), .tx_irq(tx_irq), .irq_id(irq_id),
        .irq_any(irq_any), .ext_mode(ext_mode), .rx_level(rx_level),
        .tx_level(tx_level)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_ext();
        return (rx_lvl_reg | tx_lvl_reg | flow_hi_reg | flow_lo_reg) != 0;
    endfunction

    function automatic int exp_trig(bit is_rx);
        int r = is_rx ? rx_lvl_reg : tx_lvl_reg;
        int s = is_rx ? rx_legacy_sel : tx_legacy_sel;
        if (exp_ext()) return (r == 0) ? 1 : ((r > 128) ? 128 : r);
        case (s)
            0: return 8;
            1: return 16;
            2: return is_rx ? 56 : 32;
            default: return is_rx ? 60 : 56;
        endcase
    endfunction

    function automatic int tmo_limit();
        int d = 5 + wlen_sel;
        int st = !stop_sel ? 2 : ((wlen_sel == 0) ? 3 : 4);
        return 4 * (2 * (1 + d + parity_en) + st);
    endfunction

    // One clock: model from held inputs, edge, then compare outputs.
    task automatic cyc();
        bit e_rx, e_ext, below, empty, set;
        int e_rl, e_tl, e_id;
        e_rx  = rx_count >= exp_trig(1);
        e_ext = exp_ext();
        e_rl  = (rx_count > 128) ? 128 : rx_count;
        e_tl  = (tx_count > 128) ? 128 : tx_count;
        below = tx_count < exp_trig(0);
        empty = tx_count == 0;
        set   = (below && !m_pb) || (empty && !m_pe);
        if (!below) m_tx = 0; else if (set) m_tx = 1; else if (isr_rd) m_tx = 0;
        m_pb = below; m_pe = empty;
        @(posedge clk); #2;
        chk("R4 rx_data_irq", rx_data_irq, e_rx);
        chk("R1 ext_mode", ext_mode, e_ext);
        chk("R5 tx_irq", tx_irq, m_tx);
        chk("R9 rx_level", rx_level, e_rl);
        chk("R9 tx_level", tx_level, e_tl);
        e_id = e_rx ? 1 : (rx_timeout_irq ? 2 : (m_tx ? 3 : 0));
        chk("R8 irq_id", irq_id, e_id);
        chk("R8 irq_any", irq_any, e_id != 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            half_tick = 1'b1; cyc(); half_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int lim;
        void'($urandom(32'h5eed_0042));
        // R10 reset state
        rx_count = 8'd90; tx_count = 8'd0; rx_lvl_reg = 8'd3;
        repeat (3) @(posedge clk);
        #2;
        chk("R10 rx_data_irq", rx_data_irq, 0);
        chk("R10 tx_irq", tx_irq, 0);
        chk("R10 ext_mode", ext_mode, 0);
        chk("R10 rx_level", rx_level, 0);
        chk("R10 irq_id", irq_id, 0);
        rst_n = 1'b1; rx_count = 0; rx_lvl_reg = 0;
        cyc(); // R5: empty after reset sets tx_irq
        chk("R5 tx_irq after reset", tx_irq, 1);

        // R2 zero level read as one, via flow_lo only
        flow_lo_reg = 8'd4; rx_count = 0; cyc();
        chk("R2 level zero count zero", rx_data_irq, 0);
        rx_count = 1; cyc();
        chk("R2 level zero count one", rx_data_irq, 1);
        // R2 top level and clamp
        rx_lvl_reg = 8'd128; rx_count = 127; cyc();
        chk("R2 level 128 at 127", rx_data_irq, 0);
        rx_count = 128; cyc();
        chk("R2 level 128 at 128", rx_data_irq, 1);
        rx_lvl_reg = 8'd200; rx_count = 200; cyc();
        chk("R9 rx_level clamp", rx_level, 128);
        // R3 legacy codes
        rx_lvl_reg = 0; flow_lo_reg = 0; rx_legacy_sel = 2'd3; rx_count = 59; cyc();
        chk("R3 legacy rx 60 at 59", rx_data_irq, 0);
        rx_count = 60; cyc();
        chk("R3 legacy rx 60 at 60", rx_data_irq, 1);
        chk("R1 ext off", ext_mode, 0);

        // R5 directed: below entry, status read, empty re-set, refill
        tx_lvl_reg = 8'd10; rx_count = 0; tx_count = 20; cyc();
        chk("R5 above clears", tx_irq, 0);
        tx_count = 5; cyc();
        chk("R5 below sets", tx_irq, 1);
        isr_rd = 1; cyc(); isr_rd = 0;
        chk("R5 status read clears", tx_irq, 0);
        cyc();
        chk("R5 stays clear", tx_irq, 0);
        tx_count = 0; cyc();
        chk("R5 empty re-sets", tx_irq, 1);
        tx_count = 12; cyc();
        chk("R5 refill clears", tx_irq, 0);

        // Random phase, no ticks so timeout must stay low
        for (int i = 0; i < 400; i++) begin
            bit ext = $urandom_range(0, 1);
            rx_lvl_reg  = ext ? 8'($urandom_range(0, 140)) : 8'd0;
            tx_lvl_reg  = ext ? 8'($urandom_range(0, 140)) : 8'd0;
            flow_hi_reg = (ext && $urandom_range(0, 1)) ? 8'd9 : 8'd0;
            flow_lo_reg = 8'd0;
            rx_legacy_sel = 2'($urandom_range(0, 3));
            tx_legacy_sel = 2'($urandom_range(0, 3));
            rx_count = 8'($urandom_range(0, 128));
            tx_count = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(0, 140));
            isr_rd  = $urandom_range(0, 3) == 0;
            rhr_rd  = $urandom_range(0, 3) == 0;
            rx_push = $urandom_range(0, 3) == 0;
            cyc();
            chk("R6 no ticks no timeout", rx_timeout_irq, 0);
        end
        isr_rd = 0; rhr_rd = 0; rx_push = 0;

        // R6 timeout: 8 data, parity, 2 stop => 96 half ticks
        rx_lvl_reg = 8'd100; tx_lvl_reg = 8'd1; flow_hi_reg = 0;
        tx_count = 128; rx_count = 5;
        wlen_sel = 2'd3; parity_en = 1; stop_sel = 1;
        lim = tmo_limit();
        rx_push = 1; cyc(); rx_push = 0;
        ticks(lim - 1);
        chk("R6 one tick short", rx_timeout_irq, 0);
        ticks(1);
        chk("R6 timeout at limit", rx_timeout_irq, 1);
        chk("R8 timeout code", irq_id, 2);
        rx_count = 100; cyc();
        chk("R8 rx data wins", irq_id, 1);
        rx_count = 5;
        rhr_rd = 1; cyc(); rhr_rd = 0;
        chk("R7 read clears timeout", rx_timeout_irq, 0);
        // R7 push restarts mid count
        ticks(50);
        rx_push = 1; cyc(); rx_push = 0;
        ticks(lim - 1);
        chk("R7 push restarted count", rx_timeout_irq, 0);
        ticks(1);
        chk("R7 timeout after restart", rx_timeout_irq, 1);
        // R6 five data bits, 1.5 stop, no parity => 60
        wlen_sel = 2'd0; parity_en = 0; stop_sel = 1;
        lim = tmo_limit();
        rhr_rd = 1; cyc(); rhr_rd = 0;
        ticks(lim - 1);
        chk("R6 1.5 stop short", rx_timeout_irq, 0);
        ticks(1);
        chk("R6 1.5 stop limit", rx_timeout_irq, 1);
        // R7 empty holds idle
        rx_count = 0; cyc();
        chk("R7 empty clears timeout", rx_timeout_irq, 0);
        ticks(lim + 10);
        chk("R7 empty stays idle", rx_timeout_irq, 0);
        finish_run();
    end
endmodule